// File: doc/BRIEF.md
# Dual-Pair Lockstep Controller with Checkpoint Restart

The block supervises two redundant compute pairs. Each pair is two identical modules running in lockstep, and the block compares the two copies of each pair every cycle. One pair is active and the other is standby. While the active pair agrees, its results are released downstream. At a fixed cycle interval, the active pair's architectural state is saved into a small checkpoint store.

When the active pair's copies disagree, its output for that cycle is dropped and the pair is marked faulty. The standby pair becomes active and receives a restart strobe together with the last saved checkpoint, so it resumes from that state. The faulty pair never returns to service.

Two further cases are unrecoverable: both pairs disagreeing in the same cycle, or a second failure once the spare is already used. In either case the controller stops for good and raises an unrecoverable-error output.

Top module: `lockstep_spare_ctrl`

## Requirements
- R1: During and right after reset:
  - `active_pair` is 0 and `pair_fault` is 0.
  - `unrecov`, `out_valid`, `restart` and `ckpt_commit` are all 0.
- R2: Module index k = 2*p + c, where p is the pair and c is the copy. Pair p mismatches in a cycle when any of these holds:
  - the valid strobes of copies 0 and 1 differ;
  - both copies are valid and their data differ;
  - their state words differ.

  Two invalid copies with different data do not mismatch.
- R3: `out_valid` is set one cycle after a running cycle in which the active pair agrees and its copy 0 is valid. `out_data` then equals that copy's data. In every other case `out_valid` is 0, including a cycle in which the active pair mismatches.
- R4: A cycle counter starts at reset. A checkpoint is due on every `CKPT_INTERVAL`-th clock edge, so the first is due at edge `CKPT_INTERVAL` after reset. When the active pair agrees at a due edge, copy 0's state is stored and `ckpt_commit` pulses for one cycle after that edge.
- R5: If the active pair mismatches at a due edge, nothing is stored and no `ckpt_commit` pulse occurs. A later restart delivers the earlier checkpoint.
- R6: When the active pair mismatches and the standby pair is healthy and agrees, the following happens after that edge:
  - `active_pair` flips;
  - the failed pair's `pair_fault` bit is set and stays set;
  - one cycle later `restart` pulses once, with `restart_state` equal to the last stored checkpoint, or 0 if none was stored.
- R7: A takeover resets the checkpoint counter. The next checkpoint is due `CKPT_INTERVAL` edges after the takeover edge.
- R8: The controller halts after the edge of any cycle in which:
  - both pairs mismatch; or
  - the active pair mismatches while the standby is already faulty.

  On halting, the fault bit of each mismatching pair is set and `unrecov` is set permanently. From then on `out_valid`, `ckpt_commit` and `restart` stay 0 and `active_pair` does not change.
- R9: A mismatch confined to the standby pair leaves `active_pair`, `pair_fault`, `unrecov` and the released output unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mod_valid | input | 4 | Result valid strobe per module (index 2*pair+copy) |
| mod_data | input | 4*DATA_W | Result bus per module |
| mod_state | input | 4*STATE_W | Architectural state word per module |
| out_valid | output | 1 | Released result valid |
| out_data | output | DATA_W | Released result |
| ckpt_commit | output | 1 | Pulse: checkpoint stored |
| restart | output | 1 | Pulse: newly active pair restarts from `restart_state` |
| restart_state | output | STATE_W | Checkpoint delivered with the restart |
| active_pair | output | 1 | Pair whose results are released |
| pair_fault | output | 2 | Sticky fault flag per pair |
| unrecov | output | 1 | Sticky unrecoverable-error flag |

## Verification
Two functions can fall in the same cycle: a due checkpoint and a mismatch of the active pair. The bench provokes this by corrupting one copy's state word at exactly the due edge. It then judges the outcome in three ways:
- no commit pulse follows that edge;
- the takeover still happens;
- the restart that follows carries the previous checkpoint rather than the state offered at the due edge.

A second overlap, where both pairs mismatch in one cycle, is driven directly and must end in the halted state rather than a takeover.

// File: rtl/lps_pkg.sv
package lps_pkg;
  localparam int NUM_PAIRS  = 2;
  localparam int PAIR_COPIES = 2;
  localparam int NUM_MODS   = NUM_PAIRS * PAIR_COPIES;

  typedef enum logic {
    CTL_RUN  = 1'b0,
    CTL_HALT = 1'b1
  } ctl_state_t;
endpackage

// File: rtl/lps_pair_cmp.sv
module lps_pair_cmp #(
  parameter int DATA_W  = 16,
  parameter int STATE_W = 16
) (
  input  logic               v0,
  input  logic               v1,
  input  logic [DATA_W-1:0]  d0,
  input  logic [DATA_W-1:0]  d1,
  input  logic [STATE_W-1:0] s0,
  input  logic [STATE_W-1:0] s1,
  output logic               mism
);
  logic strobe_diff, data_diff, state_diff;

  always_comb begin
    strobe_diff = v0 ^ v1;
    data_diff   = v0 && v1 && (d0 != d1);
    state_diff  = (s0 != s1);
    mism        = strobe_diff | data_diff | state_diff;
  end
endmodule

// File: rtl/lps_ckpt_timer.sv
module lps_ckpt_timer #(
  parameter int INTERVAL = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic clear,
  output logic due
);
  localparam int CNT_W = (INTERVAL > 1) ? $clog2(INTERVAL) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(INTERVAL - 1);

  logic [CNT_W-1:0] cnt;

  assign due = en && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      cnt <= '0;
    end else if (en) begin
      if (cnt == LAST) cnt <= '0;
      else             cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/lps_ckpt_store.sv
module lps_ckpt_store #(
  parameter int STATE_W = 16,
  parameter int SLOTS   = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [STATE_W-1:0] wr_data,
  output logic [STATE_W-1:0] rd_data,
  output logic               have_ckpt
);
  localparam int PTR_W = (SLOTS > 1) ? $clog2(SLOTS) : 1;
  localparam logic [PTR_W-1:0] LAST_SLOT = PTR_W'(SLOTS - 1);

  logic [STATE_W-1:0] mem [SLOTS];
  logic [PTR_W-1:0]   wr_ptr;
  logic [PTR_W-1:0]   last_ptr;

  // Storage array: no reset, synchronous read, so it maps to block RAM.
  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_ptr] <= wr_data;
    rd_data <= mem[last_ptr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr    <= '0;
      last_ptr  <= '0;
      have_ckpt <= 1'b0;
    end else if (wr_en) begin
      last_ptr  <= wr_ptr;
      have_ckpt <= 1'b1;
      wr_ptr    <= (wr_ptr == LAST_SLOT) ? '0 : wr_ptr + 1'b1;
    end
  end
endmodule

// File: rtl/lockstep_spare_ctrl.sv
module lockstep_spare_ctrl
  import lps_pkg::*;
#(
  parameter int DATA_W        = 16,
  parameter int STATE_W       = 16,
  parameter int CKPT_INTERVAL = 8,
  parameter int CKPT_SLOTS    = 2
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [NUM_MODS-1:0]           mod_valid,
  input  logic [NUM_MODS*DATA_W-1:0]    mod_data,
  input  logic [NUM_MODS*STATE_W-1:0]   mod_state,
  output logic                          out_valid,
  output logic [DATA_W-1:0]             out_data,
  output logic                          ckpt_commit,
  output logic                          restart,
  output logic [STATE_W-1:0]            restart_state,
  output logic                          active_pair,
  output logic [NUM_PAIRS-1:0]          pair_fault,
  output logic                          unrecov
);
  ctl_state_t         ctl;
  logic [NUM_PAIRS-1:0] p_mism;
  logic [NUM_PAIRS-1:0] p_v0;
  logic [DATA_W-1:0]  p_d0 [NUM_PAIRS];
  logic [STATE_W-1:0] p_s0 [NUM_PAIRS];

  for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
    localparam int M0 = p * PAIR_COPIES;
    localparam int M1 = M0 + 1;
    lps_pair_cmp #(.DATA_W(DATA_W), .STATE_W(STATE_W)) i_cmp (
      .v0   (mod_valid[M0]),
      .v1   (mod_valid[M1]),
      .d0   (mod_data[M0*DATA_W +: DATA_W]),
      .d1   (mod_data[M1*DATA_W +: DATA_W]),
      .s0   (mod_state[M0*STATE_W +: STATE_W]),
      .s1   (mod_state[M1*STATE_W +: STATE_W]),
      .mism (p_mism[p])
    );
    assign p_v0[p] = mod_valid[M0];
    assign p_d0[p] = mod_data[M0*DATA_W +: DATA_W];
    assign p_s0[p] = mod_state[M0*STATE_W +: STATE_W];
  end

  logic standby;
  logic act_mism, stby_mism, stby_bad;
  logic running, do_halt, do_takeover, due, ckpt_wr;
  logic restart_pend;
  logic [STATE_W-1:0] ckpt_rd;
  logic have_ckpt;

  always_comb begin
    standby     = ~active_pair;
    act_mism    = p_mism[active_pair];
    stby_mism   = p_mism[standby];
    stby_bad    = stby_mism | pair_fault[standby];
    running     = (ctl == CTL_RUN);
    do_halt     = running && act_mism && stby_bad;
    do_takeover = running && act_mism && !stby_bad;
    ckpt_wr     = due && !act_mism;
  end

  lps_ckpt_timer #(.INTERVAL(CKPT_INTERVAL)) i_timer (
    .clk   (clk),
    .rst   (rst),
    .en    (running),
    .clear (do_takeover),
    .due   (due)
  );

  lps_ckpt_store #(.STATE_W(STATE_W), .SLOTS(CKPT_SLOTS)) i_store (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (ckpt_wr),
    .wr_data   (p_s0[active_pair]),
    .rd_data   (ckpt_rd),
    .have_ckpt (have_ckpt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl           <= CTL_RUN;
      active_pair   <= 1'b0;
      pair_fault    <= '0;
      unrecov       <= 1'b0;
      out_valid     <= 1'b0;
      out_data      <= '0;
      ckpt_commit   <= 1'b0;
      restart       <= 1'b0;
      restart_pend  <= 1'b0;
      restart_state <= '0;
    end else begin
      out_valid    <= 1'b0;
      ckpt_commit  <= 1'b0;
      restart      <= 1'b0;
      restart_pend <= 1'b0;
      if (do_halt) begin
        ctl                     <= CTL_HALT;
        unrecov                 <= 1'b1;
        pair_fault[active_pair] <= 1'b1;
        if (stby_mism) pair_fault[standby] <= 1'b1;
      end else if (do_takeover) begin
        pair_fault[active_pair] <= 1'b1;
        active_pair             <= standby;
        restart_pend            <= 1'b1;
      end else if (running) begin
        out_valid   <= p_v0[active_pair];
        out_data    <= p_d0[active_pair];
        ckpt_commit <= ckpt_wr;
      end
      if (restart_pend && running && !do_halt) begin
        restart       <= 1'b1;
        restart_state <= have_ckpt ? ckpt_rd : '0;
      end
    end
  end
endmodule

// File: rtl/lps_checker.sv
module lps_checker (
  input logic       clk,
  input logic       rst,
  input logic       out_valid,
  input logic       ckpt_commit,
  input logic       restart,
  input logic       active_pair,
  input logic [1:0] pair_fault,
  input logic       unrecov,
  input logic       act_mism
);
  AST_OUT_NEEDS_AGREE: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(!act_mism)); // R3

  AST_MISMATCH_ACTS: assert property (@(posedge clk) disable iff (rst)
    (!unrecov && act_mism) |=> ((active_pair != $past(active_pair)) || unrecov)); // R6

  AST_RESTART_FOLLOWS_SWAP: assert property (@(posedge clk) disable iff (rst)
    ((active_pair != $past(active_pair)) && !unrecov) |=> (restart || unrecov)); // R6

  AST_FAULT_STICKY: assert property (@(posedge clk) disable iff (rst)
    ((pair_fault & $past(pair_fault)) == $past(pair_fault))); // R6

  AST_HALT_STICKY: assert property (@(posedge clk) disable iff (rst)
    unrecov |=> unrecov); // R8

  AST_HALT_SILENT: assert property (@(posedge clk) disable iff (rst)
    unrecov |-> (!out_valid && !ckpt_commit)); // R8
endmodule

bind lockstep_spare_ctrl lps_checker i_lps_checker (
  .clk         (clk),
  .rst         (rst),
  .out_valid   (out_valid),
  .ckpt_commit (ckpt_commit),
  .restart     (restart),
  .active_pair (active_pair),
  .pair_fault  (pair_fault),
  .unrecov     (unrecov),
  .act_mism    (act_mism)
);

// File: tb/test_lockstep_spare_ctrl.sv
module test_lockstep_spare_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 16;
  localparam int SW = 16;
  localparam int IVL = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [3:0]    mv;
  logic [4*DW-1:0] md;
  logic [4*SW-1:0] ms;
  logic          out_valid, ckpt_commit, restart, active_pair, unrecov;
  logic [DW-1:0] out_data;
  logic [SW-1:0] restart_state;
  logic [1:0]    pair_fault;
  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lockstep_spare_ctrl #(.DATA_W(DW), .STATE_W(SW), .CKPT_INTERVAL(IVL), .CKPT_SLOTS(2))
  i_lockstep_spare_ctrl (
    .clk(clk), .rst(rst), .mod_valid(mv), .mod_data(md), .mod_state(ms),
    .out_valid(out_valid), .out_data(out_data), .ckpt_commit(ckpt_commit),
    .restart(restart), .restart_state(restart_state), .active_pair(active_pair),
    .pair_fault(pair_fault), .unrecov(unrecov)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic agree(input logic v, input logic [DW-1:0] d, input logic [SW-1:0] s);
    mv = {4{v}};
    md = {4{d}};
    ms = {4{s}};
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    agree(1'b1, '0, '0);
    step();
    step();
    rst = 1'b0;
  endtask

  task automatic t_reset();
    rst = 1'b1;
    agree(1'b1, 16'h1234, 16'h0);
    md[DW +: DW] = 16'hFFFF;
    step();
    step();
    check("R1 active", active_pair, 0);
    check("R1 fault", pair_fault, 0);
    check("R1 unrecov", unrecov, 0);
    check("R1 out_valid", out_valid, 0);
    check("R1 restart", restart, 0);
    check("R1 commit", ckpt_commit, 0);
    rst = 1'b0;
  endtask

  task automatic t_release();
    do_reset();
    for (int i = 0; i < 6; i++) begin
      agree(1'b1, 16'hA000 + 16'(i * 37), 16'(i));
      step();
      check("R3 valid", out_valid, 1);
      check("R3 data", out_data, 16'hA000 + 16'(i * 37));
    end
    agree(1'b0, 16'h5555, 16'h7);
    step();
    check("R3 invalid copy", out_valid, 0);
  endtask

  task automatic t_mismatch_kinds();
    for (int k = 0; k < 4; k++) begin
      do_reset();
      agree(1'b1, 16'h00C0, 16'h0011);
      case (k)
        0: mv[1] = 1'b0;
        1: md[DW +: DW] = 16'h00C1;
        2: ms[SW +: SW] = 16'h0012;
        default: begin
          mv[0] = 1'b0;
          mv[1] = 1'b0;
          md[DW +: DW] = 16'hBEEF;
        end
      endcase
      step();
      check("R2 takeover on mismatch kind", active_pair, (k < 3) ? 1 : 0);
      check("R3 suppressed", out_valid, 0);
      check("R2 fault flag", pair_fault, (k < 3) ? 2'b01 : 2'b00);
    end
  endtask

  task automatic t_checkpoint();
    do_reset();
    for (int e = 1; e <= 9; e++) begin
      agree(1'b1, 16'(e), 16'h0100 + 16'(e));
      step();
      check("R4 commit timing", ckpt_commit, (e % IVL == 0) ? 1 : 0);
    end
    agree(1'b1, 16'h0A, 16'h010A);
    md[DW +: DW] = 16'hDEAD;
    step();
    check("R6 active flips", active_pair, 1);
    check("R6 fault sticky", pair_fault, 2'b01);
    check("R6 restart not yet", restart, 0);
    agree(1'b1, 16'h0B, 16'h010B);
    step();
    check("R6 restart pulse", restart, 1);
    check("R6 restart state", restart_state, 16'h0108);
    for (int e = 12; e <= 15; e++) begin
      agree(1'b1, 16'(e), 16'h0100 + 16'(e));
      step();
      check("R6 single restart", restart, 0);
      check("R7 commit after takeover", ckpt_commit, (e == 14) ? 1 : 0);
      check("R6 fault held", pair_fault, 2'b01);
    end
  endtask

  task automatic t_due_mismatch();
    do_reset();
    for (int e = 1; e <= 7; e++) begin
      agree(1'b1, 16'(e), 16'h0200 + 16'(e));
      step();
    end
    agree(1'b1, 16'h8, 16'h0208);
    ms[SW +: SW] = 16'h0999;
    step();
    check("R5 no commit at due mismatch", ckpt_commit, 0);
    check("R5 takeover still", active_pair, 1);
    agree(1'b1, 16'h9, 16'h0209);
    step();
    check("R5 restart pulse", restart, 1);
    check("R5 earlier checkpoint", restart_state, 16'h0204);
  endtask

  task automatic t_no_ckpt();
    do_reset();
    agree(1'b1, 16'h1, 16'h0301);
    step();
    mv[0] = 1'b0;
    step();
    check("R6 takeover", active_pair, 1);
    agree(1'b1, 16'h3, 16'h0303);
    step();
    check("R6 restart without checkpoint", restart, 1);
    check("R6 zero state", restart_state, 0);
  endtask

  task automatic t_standby();
    do_reset();
    for (int i = 0; i < 3; i++) begin
      agree(1'b1, 16'h0E00 + 16'(i), 16'h5);
      md[3*DW +: DW] = 16'hF00D;
      ms[3*SW +: SW] = 16'h0006;
      step();
      check("R9 active", active_pair, 0);
      check("R9 fault", pair_fault, 0);
      check("R9 unrecov", unrecov, 0);
      check("R9 out_valid", out_valid, 1);
      check("R9 out_data", out_data, 16'h0E00 + 16'(i));
    end
  endtask

  task automatic t_halt_both();
    do_reset();
    agree(1'b1, 16'h1, 16'h1);
    step();
    md[DW +: DW] = 16'h2222;
    md[3*DW +: DW] = 16'h3333;
    step();
    check("R8 unrecov", unrecov, 1);
    check("R8 both faults", pair_fault, 2'b11);
    check("R8 out silent", out_valid, 0);
    check("R8 active held", active_pair, 0);
    for (int e = 3; e <= 9; e++) begin
      agree(1'b1, 16'(e), 16'(e));
      step();
      check("R8 sticky", unrecov, 1);
      check("R8 no output", out_valid, 0);
      check("R8 no commit", ckpt_commit, 0);
      check("R8 no restart", restart, 0);
    end
  endtask

  task automatic t_halt_second();
    do_reset();
    agree(1'b1, 16'h1, 16'h1);
    mv[1] = 1'b0;
    step();
    check("R6 first takeover", active_pair, 1);
    agree(1'b1, 16'h2, 16'h2);
    step();
    md[3*DW +: DW] = 16'h4444;
    step();
    check("R8 second failure halts", unrecov, 1);
    check("R8 faults", pair_fault, 2'b11);
    check("R8 active unchanged", active_pair, 1);
    check("R8 no restart", restart, 0);
    agree(1'b1, 16'h4, 16'h4);
    step();
    check("R8 output stays off", out_valid, 0);
  endtask

  initial begin
    agree(1'b1, '0, '0);
    t_reset();
    t_release();
    t_mismatch_kinds();
    t_checkpoint();
    t_due_mismatch();
    t_no_ckpt();
    t_standby();
    t_halt_both();
    t_halt_second();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule